// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Cell

One cell of a serial interrupt priority chain. Each cell keeps its device's pending request and, while the request is held, enables a pull-down on a shared active-low request line. The acknowledge enters each cell from the neighbour nearer the CPU. A cell that holds a request when the acknowledge arrives keeps it, presents its fixed vector byte for the shared data bus, and holds its own acknowledge output low. A cell with no request passes the acknowledge on to the next cell.

Priority comes only from position. The cell nearest the CPU wins, because every cell after it never sees the acknowledge. Cells are chained by wiring `ack_o` of one cell to `ack_i` of the next. Outside the cell, the `irq_pull_o` outputs are combined as an open-drain line and the `vec_oe_o`/`vec_o` pairs as a tri-state bus.

The pass or claim decision is taken once, in the first cycle `ack_i` is high. It then holds until `ack_i` falls. This means a request that arrives during an acknowledge cannot cut it off partway through.

Top module: `dc_chain_cell`

## Requirements
- R1: After reset no request is pending: `irq_pull_o` = 0 and `vec_oe_o` = 0. `ack_o` equals `ack_i`.
- R2: A cycle with `event_i` = 1 sets the pending request, and `irq_pull_o` is 1 from the next cycle.
- R3: In the first cycle `ack_i` is high with a request pending, the cell claims the acknowledge. In that same cycle `vec_oe_o` = 1 and `ack_o` = 0.
- R4: A cell with no pending request at the rising edge of `ack_i` drives `ack_o` equal to `ack_i` for that acknowledge.
- R5: A claimed request is cleared. `irq_pull_o` is 0 from the cycle after the claim, unless `event_i` is high in the claim cycle.
- R6: A request that becomes pending while `ack_i` is already high does not claim. `ack_o` stays high and `vec_oe_o` stays 0 until `ack_i` falls. The request stays pending and claims at the next rising edge of `ack_i`.
- R7: A claim holds while `ack_i` stays high. `vec_oe_o` is 1 only while `ack_i` is high and the cell holds a claim.
- R8: `vec_o` equals the 8-bit parameter `VECTOR` while `vec_oe_o` = 1, and is 0 otherwise.
- R9: In a chain with several requests pending, only the cell nearest the CPU claims an acknowledge. Cells further down see no acknowledge and stay pending.
- R10: The wired request line, the inverse of the OR of all `irq_pull_o` outputs, is low exactly while at least one cell has a request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | Local device service event, sampled each cycle |
| ack_i | input | 1 | Acknowledge from the upstream neighbour or the CPU |
| ack_o | output | 1 | Acknowledge passed to the downstream neighbour |
| irq_pull_o | output | 1 | Pull-down enable for the shared active-low request line |
| vec_o | output | VEC_W | Vector byte for the shared data bus |
| vec_oe_o | output | 1 | Output enable of the vector bus driver |

## Verification
The assertions assume the following about the inputs:
- `ack_i` only changes on a clock edge.
- `ack_i` is low for at least one cycle between acknowledges, so each acknowledge has a visible rising edge.
- `event_i` is synchronous to `clk_i`.

The bench keeps within these assumptions. It drives the CPU acknowledge and all events only at falling clock edges. It always returns the acknowledge low for at least one full cycle before raising it again. The ripple of `ack_o` into the next cell is combinational, so every cell in the chain takes its decision in the same cycle.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic {
    ROUTE_PASS  = 1'b0,
    ROUTE_CLAIM = 1'b1
  } route_e;
endpackage

// File: rtl/dc_req_hold.sv
module dc_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  // a fresh event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= event_i | (pend_q & ~take_i);
  end

  assign pend_o = pend_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> pend_o); // R2
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !event_i) |=> !pend_o); // R5
endmodule

// File: rtl/dc_ack_gate.sv
module dc_ack_gate
  import dc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic pend_i,
  output logic ack_o,
  output logic claim_o,
  output logic take_o
);
  logic   ack_q;
  route_e route_q, route_now;
  logic   rise;

  assign rise      = ack_i & ~ack_q;
  // decision frozen at the rising edge of ack_i
  assign route_now = rise ? (pend_i ? ROUTE_CLAIM : ROUTE_PASS) : route_q;
  assign claim_o   = ack_i & (route_now == ROUTE_CLAIM);
  assign ack_o     = ack_i & ~claim_o;
  assign take_o    = rise & pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      route_q <= ROUTE_PASS;
    end else begin
      ack_q   <= ack_i;
      route_q <= ack_i ? route_now : ROUTE_PASS;
    end
  end

  AST_NO_MIDGRAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && $past(ack_i) && !$past(claim_o)) |-> !claim_o); // R6
  AST_CLAIM_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_o && ack_i) |=> (!ack_i || claim_o)); // R7
endmodule

// File: rtl/dc_vec_drive.sv
module dc_vec_drive #(
  parameter int unsigned          VEC_W  = 8,
  parameter logic [VEC_W-1:0]     VECTOR = '0
) (
  input  logic             claim_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o
);
  assign vec_oe_o = claim_i;
  assign vec_o    = claim_i ? VECTOR : '0;
endmodule

// File: rtl/dc_chain_cell.sv
module dc_chain_cell #(
  parameter int unsigned      VEC_W  = 8,
  parameter logic [VEC_W-1:0] VECTOR = 8'h40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             ack_i,
  output logic             ack_o,
  output logic             irq_pull_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o
);
  logic pend, take, claim;

  dc_req_hold u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .event_i(event_i),
    .take_i (take),
    .pend_o (pend)
  );

  dc_ack_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack_i),
    .pend_i (pend),
    .ack_o  (ack_o),
    .claim_o(claim),
    .take_o (take)
  );

  dc_vec_drive #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_vec (
    .claim_i (claim),
    .vec_o   (vec_o),
    .vec_oe_o(vec_oe_o)
  );

  assign irq_pull_o = pend;

  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_oe_o && ack_o)); // R3
  AST_OE_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> ack_i); // R7
  AST_IDLE_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_pull_o && $rose(ack_i)) |-> ack_o); // R4
  AST_VEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_oe_o |-> (vec_o == '0)); // R8
endmodule

// File: tb/dc_chain_cell_test.sv
module dc_chain_cell_test;
  localparam int N = 3;
  localparam logic [7:0] VEC0 = 8'h20, VEC1 = 8'h24, VEC2 = 8'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_ack = 1'b0;
  logic [N-1:0] ev = '0;
  logic [N:0]   ack;
  logic [N-1:0] pull, oe;
  logic [7:0]   vec [N];
  logic [7:0]   bus;
  logic         irq_n;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign ack[0] = cpu_ack;

  dc_chain_cell #(.VECTOR(VEC0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev[0]), .ack_i(ack[0]),
    .ack_o(ack[1]), .irq_pull_o(pull[0]), .vec_o(vec[0]), .vec_oe_o(oe[0]));
  dc_chain_cell #(.VECTOR(VEC1)) u_c1 (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev[1]), .ack_i(ack[1]),
    .ack_o(ack[2]), .irq_pull_o(pull[1]), .vec_o(vec[1]), .vec_oe_o(oe[1]));
  dc_chain_cell #(.VECTOR(VEC2)) u_c2 (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev[2]), .ack_i(ack[2]),
    .ack_o(ack[3]), .irq_pull_o(pull[2]), .vec_o(vec[2]), .vec_oe_o(oe[2]));

  // open-drain line and tri-state bus model
  assign irq_n = ~|pull;
  always_comb begin
    bus = 8'hFF;
    for (int i = 0; i < N; i++) if (oe[i]) bus = vec[i];
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic post(input int k);
    @(negedge clk); ev[k] = 1'b1;
    @(negedge clk); ev[k] = 1'b0;
  endtask

  task automatic ack_rise();
    @(negedge clk); cpu_ack = 1'b1; #2;
  endtask

  task automatic ack_fall();
    @(negedge clk); cpu_ack = 1'b0; #2;
  endtask

  task automatic t_reset();
    chk("R1", "pull", int'(pull), 0);
    chk("R1", "oe", int'(oe), 0);
    chk("R1", "ack_out", int'(ack[3]), 0);
    chk("R10", "line idle", int'(irq_n), 1);
  endtask

  task automatic t_single();
    post(0); #2;
    chk("R2", "pull0 set", int'(pull[0]), 1);
    chk("R10", "line low", int'(irq_n), 0);
    ack_rise();
    chk("R3", "oe0", int'(oe[0]), 1);
    chk("R3", "ack blocked", int'(ack[1]), 0);
    chk("R8", "bus", int'(bus), int'(VEC0));
    @(negedge clk); #2;
    chk("R5", "pull0 cleared", int'(pull[0]), 0);
    chk("R7", "claim held", int'(oe[0]), 1);
    chk("R10", "line idle", int'(irq_n), 1);
    ack_fall();
    chk("R7", "oe off", int'(oe[0]), 0);
    chk("R8", "vec quiet", int'(vec[0]), 0);
  endtask

  task automatic t_priority();
    @(negedge clk); ev[1] = 1'b1; ev[2] = 1'b1;
    @(negedge clk); ev = '0;
    ack_rise();
    chk("R4", "cell0 passes", int'(ack[1]), 1);
    chk("R9", "oe", int'(oe), 3'b010);
    chk("R9", "bus", int'(bus), int'(VEC1));
    chk("R9", "down blocked", int'(ack[2]), 0);
    @(negedge clk); #2;
    chk("R9", "cell2 still pending", int'(pull[2]), 1);
    ack_fall();
    ack_rise();
    chk("R9", "cell2 claims", int'(oe), 3'b100);
    chk("R8", "bus2", int'(bus), int'(VEC2));
    chk("R9", "end blocked", int'(ack[3]), 0);
    ack_fall();
  endtask

  task automatic t_pass();
    ack_rise();
    chk("R4", "through chain", int'(ack[3]), 1);
    chk("R4", "no oe", int'(oe), 0);
    chk("R8", "bus floats", int'(bus), 8'hFF);
    ack_fall();
    chk("R4", "follows low", int'(ack[3]), 0);
  endtask

  task automatic t_midgrab();
    ack_rise();
    post(0); #2;
    chk("R6", "pending", int'(pull[0]), 1);
    chk("R6", "no claim", int'(oe[0]), 0);
    chk("R6", "ack kept", int'(ack[3]), 1);
    @(negedge clk); #2;
    chk("R6", "still passes", int'(ack[1]), 1);
    ack_fall();
    chk("R6", "held after", int'(pull[0]), 1);
    ack_rise();
    chk("R6", "claims next", int'(oe[0]), 1);
    chk("R6", "blocks next", int'(ack[1]), 0);
    ack_fall();
    @(negedge clk); #2;
    chk("R5", "cleared", int'(pull[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_single();
    t_priority();
    t_pass();
    t_midgrab();
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule